// File: doc/BRIEF.md
# Hybrid Additive Cellular Automaton Pattern Generator

This block is a parameterized row of N two-state cells used as a test pattern source inside a chip. On each enabled clock every cell computes a modulo-2 sum of up to three inputs: its own bit, its higher-index neighbour and its lower-index neighbour. Three per-cell coefficient vectors select which of these inputs take part. Together they form a tridiagonal dependency matrix. A fourth vector marks the cells whose sum is complemented, so those cells act as XNOR gates. All cells update together.

Each cell has its own rule. The generator can therefore be built as a non-maximal-length group automaton. Such an automaton has one long target cycle and a few short side cycles, and patterns that must never be applied can be placed on the side cycles. The default configuration has 7 cells split into uncoupled 4-cell and 3-cell sections. Every state that is nonzero in both sections lies on the 105-state target cycle. Every state that is nonzero in only one section lies on a side cycle of 15 or 7. Software loads a seed synchronously and then pulses or holds the step input to produce patterns.

Bit i of the pattern is cell i. The "left" neighbour of cell i is bit i+1 and the "right" neighbour is bit i-1.

Top module: `hca_gen`

## Requirements
- R1: While rst_n is low the pattern holds the parameter RESET_SEED, and it still holds that value in the first cycle after rst_n rises.
- R2: When load_i is high at a clock edge, the pattern takes seed_i on that edge, whatever the value of step_i.
- R3: When load_i and step_i are both low at a clock edge, the pattern keeps its value.
- R4: When step_i is high and load_i is low, the new bit i is the XOR of three terms: bit i+1 if LEFT_DEP[i] is set, bit i if SELF_DEP[i] is set, and bit i-1 if RIGHT_DEP[i] is set. The result is then inverted if INV_VEC[i] is set.
- R5: Bit N-1 has no left neighbour and bit 0 has no right neighbour. Each of them sees 0 in that position, even when its dependency bit for that side is set; the pattern does not wrap around.
- R6: With a nonzero INV_VEC, one step from the all-zero state gives exactly INV_VEC. For the 5-cell configuration with rows 10000, 01100, 01110, 00011, 00001 and INV_VEC 10101 (cells 1 to 5 mapped to bits 0 to 4), the sequence from zero is 00000, 10101, 01010, 11111 and then 00000 again (written bit 4 first).
- R7: With INV_VEC all zero, the all-zero state steps to itself.
- R8: In the default 7-cell configuration (LEFT_DEP 0110111, SELF_DEP 0011011, RIGHT_DEP 1101110, INV_VEC 0000000, written bit 6 first), the period is 105 from seed 0010001, 15 from seed 0000001 and 7 from seed 0010000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset to RESET_SEED |
| load_i | input | 1 | Synchronous seed load; takes priority over step_i |
| seed_i | input | N | Value written to the state when load_i is high |
| step_i | input | 1 | Advance the automaton by one generation |
| pattern_o | output | N | Current cell states |

## Verification
The hardest behaviour to reach from the ports is the cycle structure: a period of 105 appears only after a long unbroken run of steps started from a seed on the correct cycle. The bench loads seeds chosen on each cycle, holds step_i high, and counts steps until the seed comes back. A limit on the count catches a sequence that never returns. Wrap-around at the ends cannot be seen with the default vectors, because they leave the outer dependencies off. A second instance therefore enables every coefficient, so that a single end bit shows whether a phantom neighbour leaks in.

// File: rtl/hca_pkg.sv
package hca_pkg;

    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,
        CMD_STEP = 2'd1,
        CMD_LOAD = 2'd2
    } hca_cmd_e;

    // Loading wins over stepping.
    function automatic hca_cmd_e hca_decode(input logic load, input logic step);
        if (load)      return CMD_LOAD;
        else if (step) return CMD_STEP;
        else           return CMD_HOLD;
    endfunction

endpackage

// File: rtl/hca_ctrl.sv
module hca_ctrl
    import hca_pkg::*;
(
    input  logic     load_i,
    input  logic     step_i,
    output hca_cmd_e cmd_o
);
    always_comb begin
        cmd_o = hca_decode(load_i, step_i);
    end
endmodule

// File: rtl/hca_cell.sv
module hca_cell #(
    parameter bit USE_LEFT  = 1'b0,
    parameter bit USE_SELF  = 1'b0,
    parameter bit USE_RIGHT = 1'b0,
    parameter bit INVERT    = 1'b0
) (
    input  logic left_i,
    input  logic self_i,
    input  logic right_i,
    output logic next_o
);
    logic sum;

    always_comb begin
        sum = 1'b0;
        if (USE_LEFT)  sum = sum ^ left_i;
        if (USE_SELF)  sum = sum ^ self_i;
        if (USE_RIGHT) sum = sum ^ right_i;
        next_o = INVERT ? ~sum : sum;
    end
endmodule

// File: rtl/hca_gen.sv
module hca_gen
    import hca_pkg::*;
#(
    parameter int unsigned    N          = 7,
    parameter logic [N-1:0]   LEFT_DEP   = 7'b0110111,
    parameter logic [N-1:0]   SELF_DEP   = 7'b0011011,
    parameter logic [N-1:0]   RIGHT_DEP  = 7'b1101110,
    parameter logic [N-1:0]   INV_VEC    = 7'b0000000,
    parameter logic [N-1:0]   RESET_SEED = 7'b0010001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [N-1:0] seed_i,
    input  logic         step_i,
    output logic [N-1:0] pattern_o
);
    localparam int unsigned LAST = N - 1;

    typedef struct packed {
        logic [N-1:0] state;
    } regs_t;

    regs_t        r_d, r_q;
    logic [N-1:0] ca_next;
    hca_cmd_e     cmd;

    hca_ctrl u_ctrl (
        .load_i (load_i),
        .step_i (step_i),
        .cmd_o  (cmd)
    );

    for (genvar i = 0; i < N; i++) begin : g_cell
        logic lft;
        logic rgt;

        if (i == LAST) begin : g_left_edge
            assign lft = 1'b0;
        end else begin : g_left_in
            assign lft = r_q.state[i+1];
        end

        if (i == 0) begin : g_right_edge
            assign rgt = 1'b0;
        end else begin : g_right_in
            assign rgt = r_q.state[i-1];
        end

        hca_cell #(
            .USE_LEFT  (LEFT_DEP[i]),
            .USE_SELF  (SELF_DEP[i]),
            .USE_RIGHT (RIGHT_DEP[i]),
            .INVERT    (INV_VEC[i])
        ) u_cell (
            .left_i  (lft),
            .self_i  (r_q.state[i]),
            .right_i (rgt),
            .next_o  (ca_next[i])
        );
    end

    always_comb begin
        r_d = r_q;
        unique case (cmd)
            CMD_LOAD: r_d.state = seed_i;
            CMD_STEP: r_d.state = ca_next;
            default:  r_d.state = r_q.state;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q.state <= RESET_SEED;
        else        r_q       <= r_d;
    end

    assign pattern_o = r_q.state;

    // R1
    reset_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pattern_o == RESET_SEED);

    // R2
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> pattern_o == $past(seed_i));

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(pattern_o));

    // R6
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_i && pattern_o == '0) |=> pattern_o == INV_VEC);

endmodule

// File: tb/hca_gen_tb_top.sv
module hca_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic       step = 1'b0;
    logic [6:0] seed7 = '0;
    logic [4:0] seed5 = '0;
    logic [3:0] seed4 = '0;
    logic [6:0] pat7;
    logic [4:0] pat5;
    logic [3:0] pat4;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    hca_gen dut_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed7),
        .step_i(step), .pattern_o(pat7)
    );

    hca_gen #(
        .N(5), .LEFT_DEP(5'b01110), .SELF_DEP(5'b11111), .RIGHT_DEP(5'b00100),
        .INV_VEC(5'b10101), .RESET_SEED(5'b00000)
    ) dut5_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed5),
        .step_i(step), .pattern_o(pat5)
    );

    hca_gen #(
        .N(4), .LEFT_DEP(4'b1111), .SELF_DEP(4'b1111), .RIGHT_DEP(4'b1111),
        .INV_VEC(4'b0000), .RESET_SEED(4'b0001)
    ) dut4_i (
        .clk(clk), .rst_n(rst_n), .load_i(load), .seed_i(seed4),
        .step_i(step), .pattern_o(pat4)
    );

    // one-step vectors for the default 7-cell rule (R4, R5, R7)
    localparam logic [6:0] TBL_SEED [0:5] = '{
        7'b0000001, 7'b1000000, 7'b0001000, 7'b1111111, 7'b0010000, 7'b0000000 };
    localparam logic [6:0] TBL_EXP  [0:5] = '{
        7'b0000011, 7'b0100000, 7'b0001100, 7'b1000010, 7'b0110000, 7'b0000000 };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic load_all();
        @(negedge clk);
        load = 1'b1;
        step = 1'b0;
        @(negedge clk);
        load = 1'b0;
    endtask

    task automatic step_one();
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
    endtask

    task automatic measure(input logic [6:0] s, input int exp_len, input string req);
        int cnt;
        seed7 = s;
        load_all();
        step = 1'b1;
        cnt  = 0;
        while (cnt < 200) begin
            @(negedge clk);
            cnt++;
            if (pat7 == s) break;
        end
        step = 1'b0;
        check(req, 8'(cnt), 8'(exp_len));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset hold", {1'b0, pat7}, 8'b0010001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", {1'b0, pat7}, 8'b0010001);

        for (int k = 0; k < 6; k++) begin
            seed7 = TBL_SEED[k];
            load_all();
            step_one();
            check("R4 R5 R7 table step", {1'b0, pat7}, {1'b0, TBL_EXP[k]});
        end

        // R3: idle cycles keep the value
        seed7 = 7'b1010110;
        load_all();
        repeat (3) @(negedge clk);
        check("R3 hold", {1'b0, pat7}, 8'b01010110);

        // R2: load beats step in the same cycle
        seed7 = 7'b0110011;
        @(negedge clk);
        load = 1'b1;
        step = 1'b1;
        @(negedge clk);
        load = 1'b0;
        step = 1'b0;
        check("R2 load priority", {1'b0, pat7}, 8'b00110011);

        // R8: cycle lengths
        measure(7'b0010001, 105, "R8 target period");
        measure(7'b0000001, 15,  "R8 side period 15");
        measure(7'b0010000, 7,   "R8 side period 7");

        // R6: 5-cell reference with inversion
        seed5 = 5'b00000;
        load_all();
        step_one();
        check("R6 step1", {3'b0, pat5}, 8'b00010101);
        step_one();
        check("R6 step2", {3'b0, pat5}, 8'b00001010);
        step_one();
        check("R6 step3", {3'b0, pat5}, 8'b00011111);
        step_one();
        check("R6 step4", {3'b0, pat5}, 8'b00000000);

        // R5: all coefficients enabled, ends must not wrap
        seed4 = 4'b1000;
        load_all();
        step_one();
        check("R5 top edge", {4'b0, pat4}, 8'b00001100);
        seed4 = 4'b0001;
        load_all();
        step_one();
        check("R5 bottom edge", {4'b0, pat4}, 8'b00000011);

        // R1: reset during operation
        step = 1'b1;
        repeat (4) @(negedge clk);
        step  = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 midrun reset", {1'b0, pat7}, 8'b0010001);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 midrun release", {1'b0, pat7}, 8'b0010001);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule